// File: doc/BRIEF.md
# Word-Serial GF(2^m) Polynomial-Basis Multiplier

This block multiplies two elements of the binary extension field GF(2^m), each a binary polynomial in the standard polynomial basis, and returns their product reduced by a fixed irreducible trinomial x^m + x^t + 1. Coefficient addition is carry-free XOR throughout. The default field is m = 233 with t = 74.

The first operand is held in a shift register and used 16 bits at a time. Each 16-bit word is gated by every bit of the second operand in turn. Each gated copy is placed at the word's own offset plus the selecting bit's position, and all copies are XOR-summed into a double-width accumulator. After the last word, one folding stage brings the 2m-1 bit raw product back into m bits, in two passes, and registers it. A one-cycle `start` captures both operands. A one-cycle `done` marks a valid `product`.

Top module: `gf2m_wordser_mul`

## Requirements
- R1: While and after reset, `done` and `busy` are 0 and `product` is all zeros until the first operation completes.
- R2: `product` equals op_a·op_b mod (x^m + x^t + 1), with polynomial bit i holding the coefficient of x^i. Defaults: m = 233, t = 74.
- R3: `done` is high for exactly one cycle. That cycle follows the (ceil(m/16)+1)-th rising edge after the edge that accepted `start`. This is 16 edges for the defaults.
- R4: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`, and is 0 in the `done` cycle.
- R5: A `start` pulse while `busy` is 1 is ignored. It produces no extra `done`, and the running operation returns the product of its own operands.
- R6: Operands are captured on the accepting edge. Changes on `op_a` or `op_b` while busy do not change the result.
- R7: `product` holds its value in every cycle in which `done` is 0.
- R8: Multiplying by the zero polynomial gives zero, and multiplying by the constant 1 returns the other operand unchanged.
- R9: Terms of degree up to 2m-2, such as x^(m-1)·x^(m-1), are fully reduced. The overflow that the first fold pass creates above bit m-1 is folded again.
- R10: When m is not a multiple of 16, the top word of `op_a` is zero-padded, and set bits in that partial word, including bit m-1, are weighted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication; accepted only when idle |
| op_a | input | FIELD_W | Multiplicand, consumed 16 bits per cycle |
| op_b | input | FIELD_W | Multiplier, whose bits gate each word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | FIELD_W | Reduced field product |

## Verification
The hardest situation to reach is the second fold pass. It only has work to do when the raw product has set bits high enough that the first pass spills past bit m-1. The stimulus reaches it by squaring x^(m-1), multiplying all-ones by all-ones, and using operands with the top partial word populated. Expected values come from an interleaved shift-and-reduce reference, which never forms the double-width product, so a wrong fold cannot be mirrored.

A start pulse with different operands is injected mid-run, and the operand pins are scrambled after every accepted start. A scoreboard then shows that only captured operands reach the result.

// File: rtl/gfws_pkg.sv
package gfws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FOLD = 2'd2
   } gfws_state_e;

   function automatic int words_for(input int bits, input int word_w);
      return (bits + word_w - 1) / word_w;
   endfunction
endpackage

// File: rtl/gfws_word_feed.sv
module gfws_word_feed #(
   parameter int FIELD_W = 233,
   parameter int WORD_W  = 16,
   localparam int NWORDS = gfws_pkg::words_for(FIELD_W, WORD_W),
   localparam int PAD_W  = NWORDS * WORD_W,
   localparam int IDX_W  = $clog2(NWORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [FIELD_W-1:0] opnd,
   output logic [WORD_W-1:0]  word,
   output logic [IDX_W-1:0]   idx,
   output logic               last
);
   generate
      if (NWORDS < 2) begin : g_bad
         $error("gfws_word_feed: need at least two words");
      end
   endgenerate

   logic [PAD_W-1:0] padded;
   logic [PAD_W-1:0] sh_q;
   logic [IDX_W-1:0] idx_q;

   generate
      if (PAD_W == FIELD_W) begin : g_exact
         assign padded = opnd;
      end else begin : g_pad
         assign padded = {{(PAD_W-FIELD_W){1'b0}}, opnd};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= padded;
         idx_q <= '0;
      end else if (step) begin
         sh_q  <= sh_q >> WORD_W;
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   assign word = sh_q[WORD_W-1:0];
   assign idx  = idx_q;
   assign last = (idx_q == IDX_W'(NWORDS - 1));

   assert_idx_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < NWORDS);
endmodule

// File: rtl/gfws_word_mul.sv
module gfws_word_mul #(
   parameter int FIELD_W = 233,
   parameter int WORD_W  = 16,
   localparam int PROD_W = FIELD_W + WORD_W - 1
) (
   input  logic [WORD_W-1:0]  word,
   input  logic [FIELD_W-1:0] opnd_b,
   output logic [PROD_W-1:0]  prod
);
   logic [WORD_W-1:0] gated [FIELD_W];

   generate
      for (genvar j = 0; j < FIELD_W; j++) begin : g_gate
         assign gated[j] = word & {WORD_W{opnd_b[j]}};
      end
   endgenerate

   always_comb begin
      prod = '0;
      for (int j = 0; j < FIELD_W; j++) begin
         prod = prod ^ (PROD_W'(gated[j]) << j);
      end
   end
endmodule

// File: rtl/gfws_trinomial_fold.sv
module gfws_trinomial_fold #(
   parameter int FIELD_W = 233,
   parameter int TAP     = 74,
   localparam int WIDE_W = 2 * FIELD_W - 1,
   localparam int HI_W   = FIELD_W - 1,
   localparam int MID_W  = FIELD_W + TAP - 1,
   localparam int OVF_W  = TAP - 1
) (
   input  logic [WIDE_W-1:0]  wide,
   output logic [FIELD_W-1:0] narrow
);
   generate
      if (TAP < 2 || 2 * TAP - 1 > FIELD_W) begin : g_bad
         $error("gfws_trinomial_fold: middle term out of range for two passes");
      end
   endgenerate

   logic [HI_W-1:0]  hi;
   logic [MID_W-1:0] pass1;
   logic [OVF_W-1:0] ovf;

   assign hi    = wide[WIDE_W-1:FIELD_W];
   assign pass1 = MID_W'(wide[FIELD_W-1:0]) ^ MID_W'(hi) ^ (MID_W'(hi) << TAP);
   assign ovf   = pass1[MID_W-1:FIELD_W];
   assign narrow = pass1[FIELD_W-1:0] ^ FIELD_W'(ovf) ^ (FIELD_W'(ovf) << TAP);
endmodule

// File: rtl/gf2m_wordser_mul.sv
module gf2m_wordser_mul #(
   parameter int FIELD_W = 233,
   parameter int TAP     = 74,
   parameter int WORD_W  = 16,
   localparam int NWORDS = gfws_pkg::words_for(FIELD_W, WORD_W),
   localparam int IDX_W  = $clog2(NWORDS),
   localparam int ACC_W  = 2 * FIELD_W - 1,
   localparam int PROD_W = FIELD_W + WORD_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] op_a,
   input  logic [FIELD_W-1:0] op_b,
   output logic               busy,
   output logic               done,
   output logic [FIELD_W-1:0] product
);
   import gfws_pkg::*;

   generate
      if (WORD_W < 1 || WORD_W > FIELD_W) begin : g_bad
         $error("gf2m_wordser_mul: word width out of range");
      end
   endgenerate

   gfws_state_e        state_q;
   logic [FIELD_W-1:0] b_q;
   logic [ACC_W-1:0]   acc_q;
   logic [FIELD_W-1:0] prod_q;
   logic               done_q;

   logic               accept;
   logic               step;
   logic [WORD_W-1:0]  word;
   logic [IDX_W-1:0]   idx;
   logic               last;
   logic [PROD_W-1:0]  word_prod;
   logic [ACC_W-1:0]   aligned;
   logic [FIELD_W-1:0] folded;

   assign accept = start && (state_q == ST_IDLE);
   assign step   = (state_q == ST_RUN);

   gfws_word_feed #(.FIELD_W(FIELD_W), .WORD_W(WORD_W)) u_feed (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (step),
      .opnd  (op_a),
      .word  (word),
      .idx   (idx),
      .last  (last)
   );

   gfws_word_mul #(.FIELD_W(FIELD_W), .WORD_W(WORD_W)) u_wmul (
      .word   (word),
      .opnd_b (b_q),
      .prod   (word_prod)
   );

   assign aligned = ACC_W'(word_prod) << (int'(idx) * WORD_W);

   gfws_trinomial_fold #(.FIELD_W(FIELD_W), .TAP(TAP)) u_fold (
      .wide   (acc_q),
      .narrow (folded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         b_q     <= '0;
         acc_q   <= '0;
         prod_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  b_q     <= op_b;
                  acc_q   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               acc_q <= acc_q ^ aligned;
               if (last) state_q <= ST_FOLD;
            end
            ST_FOLD: begin
               prod_q  <= folded;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign product = prod_q;

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));
   assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(b_q));
   assert_product_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));
endmodule

// File: tb/tb_gf2m_wordser_mul.sv
`timescale 1ns/1ps
module tb_gf2m_wordser_mul;
   localparam int F      = 233;
   localparam int T      = 74;
   localparam int NW     = (F + 15) / 16;
   localparam int LAT    = NW + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [F-1:0] op_a = '0;
   logic [F-1:0] op_b = '0;
   logic         busy;
   logic         done;
   logic [F-1:0] product;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [F-1:0] exp_q [$];

   always #2 clk = ~clk;

   gf2m_wordser_mul #(.FIELD_W(F), .TAP(T), .WORD_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .product(product)
   );

   task automatic chk(input bit ok, input string req, input logic [F-1:0] act,
                      input logic [F-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [F-1:0] ref_mul(input logic [F-1:0] a, input logic [F-1:0] b);
      logic [F:0] poly = '0;
      logic [F:0] r = '0;
      poly[F] = 1'b1; poly[T] = 1'b1; poly[0] = 1'b1;
      for (int i = F - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[F]) r = r ^ poly;
         if (a[i]) r = r ^ {1'b0, b};
      end
      return r[F-1:0];
   endfunction

   function automatic logic [F-1:0] rnd();
      logic [255:0] w;
      w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      return w[F-1:0];
   endfunction

   // monitor: pops the scoreboard whenever a result is announced (R2, R5)
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected done", product, '0);
         end else begin
            logic [F-1:0] e;
            e = exp_q.pop_front();
            chk(product === e, "R2 product", product, e);
         end
      end
   end

   // driver: one operation; optional mid-run start with other operands (R5)
   task automatic run_op(input logic [F-1:0] a, input logic [F-1:0] b, input bit poke);
      int k;
      logic [F-1:0] held;
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      exp_q.push_back(ref_mul(a, b));
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R4 busy after start", F'(busy), F'(1));
      op_a = rnd(); op_b = rnd();  // R6 scramble pins
      k = 1;
      forever begin
         @(negedge clk);
         if (done) break;
         if (poke && k == 3) begin
            op_a = rnd(); op_b = rnd(); start = 1'b1;
         end else begin
            start = 1'b0;
         end
         k++;
      end
      start = 1'b0;
      chk(k == LAT, "R3 latency", F'(k), F'(LAT));
      chk(busy === 1'b0, "R4 busy low at done", F'(busy), F'(0));
      held = product;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(done === 1'b0, "R3 single-cycle done", F'(done), F'(0));
         chk(product === held, "R7 product held", product, held);
      end
   endtask

   initial begin
      logic [F-1:0] one, top, ones;
      one = F'(1);
      top = '0; top[F-1] = 1'b1;
      ones = '1;
      repeat (3) @(negedge clk);
      chk(done === 1'b0, "R1 done in reset", F'(done), F'(0));
      chk(busy === 1'b0, "R1 busy in reset", F'(busy), F'(0));
      chk(product === '0, "R1 product in reset", product, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(product === '0, "R1 product after reset", product, '0);

      run_op('0, rnd(), 1'b0);             // R8 zero
      chk(product === '0, "R8 zero a", product, '0);
      run_op(rnd(), '0, 1'b0);             // R8 zero
      chk(product === '0, "R8 zero b", product, '0);
      begin
         logic [F-1:0] v;
         v = rnd();
         run_op(one, v, 1'b0);              // R8 identity
         chk(product === v, "R8 identity a", product, v);
         v = rnd();
         run_op(v, one, 1'b0);
         chk(product === v, "R8 identity b", product, v);
      end
      run_op(top, top, 1'b0);              // R9 x^(m-1) squared
      run_op(ones, ones, 1'b0);            // R9 both fold passes
      run_op(top, rnd(), 1'b0);            // R10 top partial word
      run_op({16'hFFFF, {(F-16){1'b0}}} | F'(1), rnd(), 1'b0);  // R10
      run_op(rnd(), rnd(), 1'b1);          // R5 start while busy
      run_op(rnd(), rnd(), 1'b1);          // R5
      for (int i = 0; i < 12; i++) run_op(rnd(), rnd(), i[0]);  // R2 R6 random
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 scoreboard drained", F'(exp_q.size()), '0);
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R3 watchdog act=hung exp=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule